// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This block divides a slow tick strobe into periodic or single interrupts. A prescaler counts `tick_in` pulses and gives one count strobe for every `PRE_DIV` pulses. That strobe stream is the 32.768 kHz count base. While the timer is running, each strobe decrements a 16-bit down counter. When the counter expires, the timer raises a flag. In periodic mode it then reloads and keeps running. In one-shot mode it clears its own enable bit and stops. For an interrupt rate of 2^n Hz, software loads 0x8000 >> n.

Software reaches the timer through a byte-wide port: an 8-bit address, 8-bit write data, a write strobe and combinational read data. The control register holds the following bits:
- bit 7: busy (read only)
- bits 6..4: three storage bits with no function
- bit 3: enable
- bit 2: interrupt enable
- bit 1: flag
- bit 0: mode

The reload value is split across two byte registers. A phase register shows the prescaler position, and writing zero to it restarts the count phase. The interrupt pin is high while both the flag and the interrupt enable are set.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register (0x10) reads 0x00, the reload bytes read 0x00 at 0x12 and 0x80 at 0x13, the phase register (0x20) reads 0 and `irq` is low.
- R2: A write to 0x12 sets reload bits 7..0 and a write to 0x13 sets bits 15..8; both read back. An accepted control write that turns bit 3 from 0 to 1 copies the full 16-bit reload value into the counter.
- R3: Every `PRE_DIV`-th `tick_in` pulse is a count strobe. The phase register reads the number of pulses since the last wrap, running 0 to `PRE_DIV`-1. Writing 0x00 to 0x20 sets it to 0, and writing any other value leaves it unchanged.
- R4: With the counter loaded with N≥1 and bit 3 set, the N-th count strobe sets the flag (bit 1). In periodic mode (bit 0 = 1) the counter reloads, so the flag sets again N strobes later.
- R5: In one-shot mode (bit 0 = 0) an expiry clears bit 3, and later count strobes set no flag.
- R6: Writing 1 to bit 1 clears the flag and writing 0 leaves it unchanged. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: `irq` is high exactly when the flag (bit 1) and the interrupt enable (bit 2) are both 1.
- R8: An accepted control write makes bit 7 read 1 for `BUSY_CYC` clock cycles. Control writes made while bit 7 is 1 are ignored.
- R9: Bits 6..4 store the written value and read it back, and they have no effect on counting, flag or `irq`.
- R10: Writing the reload registers while the timer runs does not change the current count; the new value is used from the next reload on.
- R11: Writing bit 3 = 1 while the timer is already enabled does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | One-cycle pulse from the slow tick source |
| bus_we | input | 1 | Write strobe for the byte port |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, flag AND interrupt enable |

## Verification
The bench counts ticks to find the edge of each expiry. It reads the flag one strobe before that edge and again at it, so a counter that expired at zero rather than at one, or reloaded one strobe late, would show the flag one strobe off.

It drives a tick pulse and a clearing write in the same cycle, where a design that let the clear win would drop an expiry. It also writes the reload register in mid-run, and it writes enable again while the timer runs. Either case would shorten the period in a design that reloaded on any enable write or fed the reload value straight into the count.

Control writes during the busy window, and non-zero phase writes, are read back through the port to show that they left no trace. The reserved bits are read back to show they have no effect.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int CNT_W = 16;

    localparam logic [7:0] ADDR_CTRL   = 8'h10;
    localparam logic [7:0] ADDR_RLD_LO = 8'h12;
    localparam logic [7:0] ADDR_RLD_HI = 8'h13;
    localparam logic [7:0] ADDR_PHASE  = 8'h20;

    localparam int B_BUSY = 7;
    localparam int B_EN   = 3;
    localparam int B_IE   = 2;
    localparam int B_FLAG = 1;
    localparam int B_MODE = 0;

    typedef struct packed {
        logic [2:0] rsv;
        logic       en;
        logic       ie;
        logic       flag;
        logic       mode;
    } ctrl_t;

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int PRE_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       clr,
    output logic       strobe,
    output logic [7:0] phase
);
    localparam int PH_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PRE_DIV - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        strobe = 1'b0;
        if (clr) begin
            s_d.ph = '0;
        end else if (tick_in) begin
            if (s_q.ph == LAST) begin
                s_d.ph = '0;
                strobe = 1'b1;
            end else begin
                s_d.ph = s_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase = 8'(s_q.ph);

    // R3
    phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase == 8'd0));

endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         step,
    input  logic [W-1:0] reload,
    output logic         expire
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = step && !start && (s_q.cnt == W'(1));
        if (start) begin
            s_d.cnt = reload;
        end else if (step) begin
            if (expire) s_d.cnt = reload;
            else        s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    reload_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (s_q.cnt == $past(reload)));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int PRE_DIV        = 4,
    parameter int BUSY_CYC       = 3,
    parameter logic [15:0] RESET_RELOAD = 16'h8000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        ctrl_t           ctrl;
        logic [CNT_W-1:0] reload;
        logic [BW-1:0]   busy_cnt;
    } top_state_t;

    top_state_t s_d, s_q;

    logic ctrl_wr, ctrl_ok, start, pre_clr, strobe, step, expire, busy;
    logic [7:0] phase;

    tt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .clr(pre_clr),
        .strobe(strobe), .phase(phase)
    );

    tt_down_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .reload(s_q.reload), .expire(expire)
    );

    always_comb begin
        busy    = (s_q.busy_cnt != '0);
        ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
        ctrl_ok = ctrl_wr && !busy;
        start   = ctrl_ok && bus_wdata[B_EN] && !s_q.ctrl.en;
        pre_clr = bus_we && (bus_addr == ADDR_PHASE) && (bus_wdata == 8'h00);
        step    = s_q.ctrl.en && strobe;

        s_d = s_q;
        if (bus_we && bus_addr == ADDR_RLD_LO) s_d.reload[7:0]  = bus_wdata;
        if (bus_we && bus_addr == ADDR_RLD_HI) s_d.reload[15:8] = bus_wdata;
        if (busy) s_d.busy_cnt = s_q.busy_cnt - 1'b1;
        if (ctrl_ok) begin
            s_d.ctrl.rsv  = bus_wdata[6:4];
            s_d.ctrl.en   = bus_wdata[B_EN];
            s_d.ctrl.ie   = bus_wdata[B_IE];
            s_d.ctrl.mode = bus_wdata[B_MODE];
            if (bus_wdata[B_FLAG]) s_d.ctrl.flag = 1'b0;
            s_d.busy_cnt = BW'(BUSY_CYC);
        end
        if (expire) begin
            s_d.ctrl.flag = 1'b1;
            if (!s_q.ctrl.mode) s_d.ctrl.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.reload   <= RESET_RELOAD;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADDR_CTRL:   bus_rdata = {busy, s_q.ctrl};
            ADDR_RLD_LO: bus_rdata = s_q.reload[7:0];
            ADDR_RLD_HI: bus_rdata = s_q.reload[15:8];
            ADDR_PHASE:  bus_rdata = phase;
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq = s_q.ctrl.flag & s_q.ctrl.ie;

    // R4
    expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> s_q.ctrl.flag);

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !s_q.ctrl.mode) |=> !s_q.ctrl.en);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_ok && bus_wdata[B_FLAG] && !expire) |=> !s_q.ctrl.flag);

    // R7
    irq_needs_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> s_q.ctrl.ie);

    // R8
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy && !expire) |=>
            $stable({s_q.ctrl.rsv, s_q.ctrl.en, s_q.ctrl.ie, s_q.ctrl.mode}));

endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [15:0] rld;
        logic        mode;
        logic        ie;
        logic [7:0]  ticks;
        logic        flag;
        logic        en;
        logic        irqx;
    } vec_t;

    // PRE_DIV = 4: one count strobe every 4 ticks
    localparam vec_t VECS [7] = '{
        '{16'd3,     1'b1, 1'b1, 8'd11, 1'b0, 1'b1, 1'b0},  // R4 one strobe short
        '{16'd3,     1'b1, 1'b1, 8'd12, 1'b1, 1'b1, 1'b1},  // R4 exact
        '{16'd2,     1'b0, 1'b1, 8'd8,  1'b1, 1'b0, 1'b1},  // R5 one-shot expiry
        '{16'd2,     1'b0, 1'b1, 8'd7,  1'b0, 1'b1, 1'b0},  // R5 before expiry
        '{16'd1,     1'b1, 1'b0, 8'd4,  1'b1, 1'b1, 1'b0},  // R7 ie off
        '{16'h0101,  1'b1, 1'b1, 8'd20, 1'b0, 1'b1, 1'b0},  // R2 high byte used
        '{16'd5,     1'b0, 1'b1, 8'd40, 1'b1, 1'b0, 1'b1}   // R5 stays stopped
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 20; i++) begin
            rd(8'h10, v);
            if (!v[7]) break;
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        wait_idle();
        wr(8'h10, d);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_in = 1'b1;
            @(negedge clk) tick_in = 1'b0;
        end
    endtask

    task automatic setup(input logic [15:0] rld, input logic [7:0] ctl);
        wr_ctrl(8'h02);
        wr(8'h12, rld[7:0]);
        wr(8'h13, rld[15:8]);
        wr(8'h20, 8'h00);
        wr_ctrl(ctl);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, v); chk("R1 ctrl", 16'(v), 16'h00);
        rd(8'h12, v); chk("R1 rld lo", 16'(v), 16'h00);
        rd(8'h13, v); chk("R1 rld hi", 16'(v), 16'h80);
        rd(8'h20, v); chk("R1 phase", 16'(v), 16'h00);
        chk("R1 irq", 16'(irq), 16'h0);

        // R2 reload readback
        wr(8'h12, 8'h34); wr(8'h13, 8'h12);
        rd(8'h12, v); chk("R2 lo", 16'(v), 16'h34);
        rd(8'h13, v); chk("R2 hi", 16'(v), 16'h12);

        // R3 prescaler phase
        tick(3);
        rd(8'h20, v); chk("R3 phase 3", 16'(v), 16'd3);
        wr(8'h20, 8'h05);
        rd(8'h20, v); chk("R3 nonzero write ignored", 16'(v), 16'd3);
        wr(8'h20, 8'h00);
        rd(8'h20, v); chk("R3 zero write clears", 16'(v), 16'd0);
        tick(5);
        rd(8'h20, v); chk("R3 wrap", 16'(v), 16'd1);

        // R8 busy window and ignored writes
        wr_ctrl(8'h00);
        rd(8'h10, v); chk("R8 busy set", 16'(v[7]), 16'h1);
        wr(8'h10, 8'h70);
        wait_idle();
        rd(8'h10, v); chk("R8 write during busy ignored", 16'(v), 16'h00);

        // R9 reserved bits stored, no effect
        wr_ctrl(8'h70);
        wait_idle();
        rd(8'h10, v); chk("R9 readback", 16'(v), 16'h70);
        tick(8);
        rd(8'h10, v); chk("R9 no counting when disabled", 16'(v), 16'h70);
        setup(16'd1, 8'h7D);
        tick(4);
        rd(8'h10, v); chk("R9 R4 expiry with rsv", 16'(v), 16'h7F);
        chk("R7 irq high", 16'(irq), 16'h1);

        // R6 write 0 to flag keeps it, write 1 clears it
        wr_ctrl(8'h7D);
        wait_idle();
        rd(8'h10, v); chk("R6 write0 keeps flag", 16'(v[1]), 16'h1);
        wr_ctrl(8'h7F);
        wait_idle();
        rd(8'h10, v); chk("R6 write1 clears flag", 16'(v[1]), 16'h0);
        chk("R7 irq low after clear", 16'(irq), 16'h0);

        // R6 expiry wins over same-cycle clear
        wr(8'h20, 8'h00);
        tick(3);
        wait_idle();
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h10; bus_wdata = 8'h7F; tick_in = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; tick_in = 1'b0;
        rd(8'h10, v); chk("R6 set wins over clear", 16'(v[1]), 16'h1);

        // Table of vectors
        foreach (VECS[i]) begin
            setup(VECS[i].rld, {4'b0000, 1'b1, VECS[i].ie, 1'b0, VECS[i].mode});
            tick(int'(VECS[i].ticks));
            rd(8'h10, v);
            chk($sformatf("R4 R5 vec%0d flag", i), 16'(v[1]), 16'(VECS[i].flag));
            chk($sformatf("R5 vec%0d en", i), 16'(v[3]), 16'(VECS[i].en));
            chk($sformatf("R7 vec%0d irq", i), 16'(irq), 16'(VECS[i].irqx));
        end

        // R5 stopped one-shot sets no further flag
        wr_ctrl(8'h06);
        tick(40);
        rd(8'h10, v); chk("R5 no flag after stop", 16'(v[1]), 16'h0);

        // R4 periodic second expiry
        setup(16'd2, 8'h0D);
        tick(8);
        wr_ctrl(8'h0F);
        tick(7);
        rd(8'h10, v); chk("R4 second period early", 16'(v[1]), 16'h0);
        tick(1);
        rd(8'h10, v); chk("R4 second period", 16'(v[1]), 16'h1);

        // R10 reload change mid-run
        setup(16'd3, 8'h0D);
        tick(4);
        wr(8'h12, 8'h01);
        tick(7);
        rd(8'h10, v); chk("R10 old count kept", 16'(v[1]), 16'h0);
        tick(1);
        rd(8'h10, v); chk("R10 expiry at old count", 16'(v[1]), 16'h1);
        wr_ctrl(8'h0F);
        tick(4);
        rd(8'h10, v); chk("R10 new reload used", 16'(v[1]), 16'h1);

        // R11 re-enable does not restart
        setup(16'd3, 8'h0D);
        tick(8);
        wr_ctrl(8'h0D);
        tick(4);
        rd(8'h10, v); chk("R11 no restart", 16'(v[1]), 16'h1);

        finish_run();
    end
endmodule